// File: doc/BRIEF.md
# Scrolling Obstacle Column Generator

This block keeps the state of four vertical obstacle columns for a 640x480 side-scrolling game. Each column has a horizontal position (its left edge) and a gap through which the player must pass. On every frame tick, while the run enable is high, all columns slide left by the current scroll speed. A column that reaches the left edge is wrapped around to the right. On that wrap it is given a fresh gap height from a pseudo-random generator, so the stream of obstacles never ends.

Two strobes raise and lower the scroll speed during play. A destroy strobe per column removes that column at once and brings it back at the right edge with a new gap. Each column raises a one-cycle scored pulse when its right edge moves past the player's fixed horizontal position. Drawing pixels is left to a separate renderer, which reads the position and gap outputs.

All state is updated on the rising clock edge, and every output is a register or a direct function of a register. Reset is synchronous and active high.

Top module: `obstacle_columns`

## Requirements
- R1: While reset is asserted, column i goes to x = 160 + 160*i, its gap top goes to 180, its gap bottom goes to 300, all scored outputs go to 0 and the scroll speed goes to 2.
- R2: On an edge where frame_tick and run_en are both 1, a column with no destroy strobe and with x greater than the speed moves to x minus the speed. When frame_tick or run_en is 0, a column with no destroy strobe keeps its x.
- R3: On a moving edge, a column with x less than or equal to the speed wraps to x + 640 - speed. It also loads a new gap. As a result, x always stays between 1 and 640 and the 160-pixel spacing between columns is kept.
- R4: The generator is a 16-bit shift register. It resets to 0xACE1 and on every clock after reset shifts left, taking in bit15^bit13^bit12^bit10. A column i that loads a gap uses the state from before that edge. It rotates that state right by 4*i bits and takes the low 9 bits as v. Its gap top is then 40 + floor(v*281/512).
- R5: The gap bottom always equals the gap top + 120. The gap top is never below 40 and the gap bottom is never above 440.
- R6: The speed rises by 1 on speed_up, to at most 6. It falls by 1 on speed_down, to at least 1. When both strobes are high in the same cycle, the speed does not change. A speed change applies to ticks from the following edge onward.
- R7: A destroy strobe on col_kill[i] sets that column's x to 640 and loads a new gap (R4) on the next edge. This happens whether or not run_en is high, and the destroy overrides a tick in the same cycle. A destroyed column does not score.
- R8: col_scored[i] is 1 for exactly one cycle after a moving edge on which the column's right edge (x + 40) goes from above 160 to at most 160.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_tick | input | 1 | One-cycle strobe per video frame |
| run_en | input | 1 | Allows movement and scoring |
| speed_up | input | 1 | Raise scroll speed by one step |
| speed_down | input | 1 | Lower scroll speed by one step |
| col_kill | input | 4 | Per-column destroy strobe |
| col_x | output | 4x10 | Left edge x of each column |
| gap_top | output | 4x9 | First row of each column's gap |
| gap_bot | output | 4x9 | Row just below each column's gap |
| col_scored | output | 4 | One-cycle pass pulse per column |

## Verification
The collisions that matter are between a destroy strobe and a frame tick on the same column, and between a speed strobe and a tick, where the old speed must still apply. The bench fires destroy strobes at random on cycles where ticks are also dense, drives speed strobes (sometimes both together) on tick cycles, and runs with run_en toggled so that destroys also occur while the column is frozen. A behavioural model compares every column's position, gap and score pulse on every clock, so any wrong priority shows up at once as a position mismatch.

// File: rtl/obst_pkg.sv
package obst_pkg;

   localparam int LFSR_W = 16;

   typedef enum logic [1:0] {
      ACT_HOLD,
      ACT_MOVE,
      ACT_WRAP,
      ACT_KILL
   } col_act_e;

   // Fibonacci step, taps 16/14/13/11
   function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
      logic fb;
      fb = s[15] ^ s[13] ^ s[12] ^ s[10];
      return {s[LFSR_W-2:0], fb};
   endfunction

endpackage

// File: rtl/obst_speed.sv
module obst_speed #(
   parameter int SPD_MIN = 1,
   parameter int SPD_MAX = 6,
   parameter int SPD_RST = 2,
   parameter int SPD_W   = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             faster,
   input  logic             slower,
   output logic [SPD_W-1:0] spd
);

   if (SPD_MIN > SPD_MAX || SPD_RST < SPD_MIN || SPD_RST > SPD_MAX) begin : g_bad_range
      $error("obst_speed: reset speed outside limits");
   end
   if (SPD_MAX >= (1 << SPD_W)) begin : g_bad_width
      $error("obst_speed: SPD_W too narrow");
   end

   if (SPD_MIN == SPD_MAX) begin : g_fixed
      logic unused_strobes;
      assign unused_strobes = faster ^ slower ^ clk ^ rst;
      assign spd = SPD_W'(SPD_MIN);
   end else begin : g_adjust
      logic [SPD_W-1:0] spd_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            spd_q <= SPD_W'(SPD_RST);
         end else if (faster && !slower && spd_q < SPD_W'(SPD_MAX)) begin
            spd_q <= spd_q + 1'b1;
         end else if (slower && !faster && spd_q > SPD_W'(SPD_MIN)) begin
            spd_q <= spd_q - 1'b1;
         end
      end
      assign spd = spd_q;
   end

endmodule

// File: rtl/obst_gap_gen.sv
module obst_gap_gen
   import obst_pkg::*;
#(
   parameter int                N_COLS   = 4,
   parameter int                Y_W      = 9,
   parameter int                SCREEN_H = 480,
   parameter int                MARGIN   = 40,
   parameter int                GAP      = 120,
   parameter int                RAND_W   = 9,
   parameter int                ROT_STEP = 4,
   parameter logic [LFSR_W-1:0] SEED     = 16'hACE1
) (
   input  logic                         clk,
   input  logic                         rst,
   output logic [N_COLS-1:0][Y_W-1:0]   cand_top
);

   localparam int RANGE = SCREEN_H - 2 * MARGIN - GAP + 1;

   if (RANGE < 1) begin : g_bad_range
      $error("obst_gap_gen: gap and margins exceed screen height");
   end
   if (RAND_W > LFSR_W || ROT_STEP * (N_COLS - 1) >= LFSR_W) begin : g_bad_slice
      $error("obst_gap_gen: random slice does not fit the register");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("obst_gap_gen: zero seed locks the register");
   end

   logic [LFSR_W-1:0] lfsr_q;

   always_ff @(posedge clk) begin
      if (rst) lfsr_q <= SEED;
      else     lfsr_q <= lfsr_step(lfsr_q);
   end

   for (genvar i = 0; i < N_COLS; i++) begin : g_col
      logic [RAND_W-1:0] v;
      logic [31:0]       prod;
      assign v    = RAND_W'({lfsr_q, lfsr_q} >> (ROT_STEP * i));
      assign prod = {{(32 - RAND_W){1'b0}}, v} * 32'(RANGE);
      assign cand_top[i] = Y_W'(32'(MARGIN) + (prod >> RAND_W));
   end

endmodule

// File: rtl/obst_column.sv
module obst_column
   import obst_pkg::*;
#(
   parameter int X_W      = 10,
   parameter int Y_W      = 9,
   parameter int SPD_W    = 3,
   parameter int COL_W    = 40,
   parameter int PLAYER_X = 160,
   parameter int PERIOD   = 640,
   parameter int RST_X    = 160,
   parameter int RST_TOP  = 180,
   parameter int GAP      = 120
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [SPD_W-1:0] spd,
   input  logic             kill,
   input  logic [Y_W-1:0]   new_top,
   output logic [X_W-1:0]   x,
   output logic [Y_W-1:0]   top,
   output logic [Y_W-1:0]   bottom,
   output logic             scored
);

   localparam logic [X_W:0] COL_W_E  = (X_W + 1)'(COL_W);
   localparam logic [X_W:0] PLAYER_E = (X_W + 1)'(PLAYER_X);

   col_act_e       act;
   logic [X_W-1:0] x_q, x_moved, spd_x;
   logic [Y_W-1:0] top_q;
   logic           scored_q, pass_now;

   assign spd_x   = X_W'(spd);
   assign x_moved = x_q - spd_x;

   always_comb begin
      act = ACT_HOLD;
      if (kill)                act = ACT_KILL;
      else if (step && x_q <= spd_x) act = ACT_WRAP;
      else if (step)           act = ACT_MOVE;
   end

   assign pass_now = (act == ACT_MOVE)
                  && ({1'b0, x_q} + COL_W_E > PLAYER_E)
                  && ({1'b0, x_moved} + COL_W_E <= PLAYER_E);

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q      <= X_W'(RST_X);
         top_q    <= Y_W'(RST_TOP);
         scored_q <= 1'b0;
      end else begin
         scored_q <= pass_now;
         case (act)
            ACT_KILL: begin
               x_q   <= X_W'(PERIOD);
               top_q <= new_top;
            end
            ACT_WRAP: begin
               x_q   <= x_q + X_W'(PERIOD) - spd_x;
               top_q <= new_top;
            end
            ACT_MOVE: x_q <= x_moved;
            default:  ;
         endcase
      end
   end

   assign x      = x_q;
   assign top    = top_q;
   assign bottom = top_q + Y_W'(GAP);
   assign scored = scored_q;

endmodule

// File: rtl/obstacle_columns.sv
module obstacle_columns
   import obst_pkg::*;
#(
   parameter int N_COLS   = 4,
   parameter int X_W      = 10,
   parameter int Y_W      = 9,
   parameter int SCREEN_W = 640,
   parameter int SCREEN_H = 480,
   parameter int SPACING  = 160,
   parameter int COL_W    = 40,
   parameter int GAP      = 120,
   parameter int MARGIN   = 40,
   parameter int PLAYER_X = 160,
   parameter int SPD_MIN  = 1,
   parameter int SPD_MAX  = 6,
   parameter int SPD_RST  = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       frame_tick,
   input  logic                       run_en,
   input  logic                       speed_up,
   input  logic                       speed_down,
   input  logic [N_COLS-1:0]          col_kill,
   output logic [N_COLS-1:0][X_W-1:0] col_x,
   output logic [N_COLS-1:0][Y_W-1:0] gap_top,
   output logic [N_COLS-1:0][Y_W-1:0] gap_bot,
   output logic [N_COLS-1:0]          col_scored
);

   localparam int PERIOD  = N_COLS * SPACING;
   localparam int FIRST_X = PERIOD - (N_COLS - 1) * SPACING;
   localparam int MID_TOP = MARGIN + (SCREEN_H - 2 * MARGIN - GAP) / 2;
   localparam int SPD_W   = $clog2(SPD_MAX + 1);

   if (PERIOD < SCREEN_W) begin : g_bad_period
      $error("obstacle_columns: columns do not cover the screen width");
   end
   if (PERIOD >= (1 << X_W)) begin : g_bad_xw
      $error("obstacle_columns: X_W too narrow for the wrap period");
   end
   if (SCREEN_H >= (1 << Y_W)) begin : g_bad_yw
      $error("obstacle_columns: Y_W too narrow for the screen height");
   end
   if (SPD_MIN < 1 || SPD_MAX >= SPACING) begin : g_bad_spd
      $error("obstacle_columns: speed limits out of range");
   end

   logic                       step;
   logic [SPD_W-1:0]           spd;
   logic [N_COLS-1:0][Y_W-1:0] cand_top;

   assign step = frame_tick & run_en;

   obst_speed #(
      .SPD_MIN (SPD_MIN),
      .SPD_MAX (SPD_MAX),
      .SPD_RST (SPD_RST),
      .SPD_W   (SPD_W)
   ) u_speed (
      .clk    (clk),
      .rst    (rst),
      .faster (speed_up),
      .slower (speed_down),
      .spd    (spd)
   );

   obst_gap_gen #(
      .N_COLS   (N_COLS),
      .Y_W      (Y_W),
      .SCREEN_H (SCREEN_H),
      .MARGIN   (MARGIN),
      .GAP      (GAP)
   ) u_gap (
      .clk      (clk),
      .rst      (rst),
      .cand_top (cand_top)
   );

   for (genvar i = 0; i < N_COLS; i++) begin : g_col
      obst_column #(
         .X_W      (X_W),
         .Y_W      (Y_W),
         .SPD_W    (SPD_W),
         .COL_W    (COL_W),
         .PLAYER_X (PLAYER_X),
         .PERIOD   (PERIOD),
         .RST_X    (FIRST_X + i * SPACING),
         .RST_TOP  (MID_TOP),
         .GAP      (GAP)
      ) u_col (
         .clk     (clk),
         .rst     (rst),
         .step    (step),
         .spd     (spd),
         .kill    (col_kill[i]),
         .new_top (cand_top[i]),
         .x       (col_x[i]),
         .top     (gap_top[i]),
         .bottom  (gap_bot[i]),
         .scored  (col_scored[i])
      );
   end

endmodule

// File: rtl/obstacle_columns_chk.sv
module obstacle_columns_chk #(
   parameter int N_COLS   = 4,
   parameter int X_W      = 10,
   parameter int Y_W      = 9,
   parameter int SCREEN_H = 480,
   parameter int SPACING  = 160,
   parameter int MARGIN   = 40
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       frame_tick,
   input logic                       run_en,
   input logic [N_COLS-1:0]          col_kill,
   input logic [N_COLS-1:0][X_W-1:0] col_x,
   input logic [N_COLS-1:0][Y_W-1:0] gap_top,
   input logic [N_COLS-1:0][Y_W-1:0] gap_bot,
   input logic [N_COLS-1:0]          col_scored
);

   localparam int PERIOD = N_COLS * SPACING;

   for (genvar i = 0; i < N_COLS; i++) begin : g_chk
      // R2: frozen column keeps its place
      a_r2_hold: assert property (@(posedge clk) disable iff (rst)
         (!(frame_tick && run_en) && !col_kill[i]) |=> $stable(col_x[i]));

      // R3: position stays inside the wrap window
      a_r3_x_window: assert property (@(posedge clk) disable iff (rst)
         (col_x[i] >= X_W'(1)) && (col_x[i] <= X_W'(PERIOD)));

      // R5: gap inside the legal band
      a_r5_gap_band: assert property (@(posedge clk) disable iff (rst)
         (gap_top[i] >= Y_W'(MARGIN)) && (gap_bot[i] <= Y_W'(SCREEN_H - MARGIN)));

      // R7: destroy lands at the right edge
      a_r7_kill_edge: assert property (@(posedge clk) disable iff (rst)
         col_kill[i] |=> (col_x[i] == X_W'(PERIOD)));

      // R8: score only after a real move of this column
      a_r8_score_cause: assert property (@(posedge clk) disable iff (rst)
         col_scored[i] |-> $past(frame_tick && run_en && !col_kill[i]));

      // R8: pulse lasts one cycle
      a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
         col_scored[i] |=> !col_scored[i]);
   end

endmodule

bind obstacle_columns obstacle_columns_chk #(
   .N_COLS   (N_COLS),
   .X_W      (X_W),
   .Y_W      (Y_W),
   .SCREEN_H (SCREEN_H),
   .SPACING  (SPACING),
   .MARGIN   (MARGIN)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .frame_tick (frame_tick),
   .run_en     (run_en),
   .col_kill   (col_kill),
   .col_x      (col_x),
   .gap_top    (gap_top),
   .gap_bot    (gap_bot),
   .col_scored (col_scored)
);

// File: tb/obstacle_columns_test.sv
module obstacle_columns_test;

   localparam int CLK_NS = 10;
   localparam int NC     = 4;

   logic                  clk = 1'b0;
   logic                  rst = 1'b1;
   logic                  frame_tick = 1'b0, run_en = 1'b0;
   logic                  speed_up = 1'b0, speed_down = 1'b0;
   logic [NC-1:0]         col_kill = '0;
   logic [NC-1:0][9:0]    col_x;
   logic [NC-1:0][8:0]    gap_top, gap_bot;
   logic [NC-1:0]         col_scored;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;
   bit compare  = 1'b0;

   // behavioural reference state
   int m_x[NC];
   int m_top[NC];
   int m_sc[NC];
   int m_spd;
   int m_rnd;

   obstacle_columns uut (
      .clk(clk), .rst(rst), .frame_tick(frame_tick), .run_en(run_en),
      .speed_up(speed_up), .speed_down(speed_down), .col_kill(col_kill),
      .col_x(col_x), .gap_top(gap_top), .gap_bot(gap_bot), .col_scored(col_scored)
   );

   always #(CLK_NS / 2) clk = ~clk;

   function automatic int next_rnd(int s);
      int fb;
      fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
      return ((s << 1) | fb) & 16'hFFFF;
   endfunction

   function automatic int gap_for(int s, int i);
      int r;
      r = ((s >> (4 * i)) | (s << (16 - 4 * i))) & 16'hFFFF;
      return 40 + (((r & 511) * 281) >> 9);
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: update at each edge from values held before it
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NC; i++) begin
            m_x[i] = 160 + 160 * i;
            m_top[i] = 180;
            m_sc[i] = 0;
         end
         m_spd = 2;
         m_rnd = 16'hACE1;
      end else begin
         for (int i = 0; i < NC; i++) begin
            m_sc[i] = 0;
            if (col_kill[i]) begin
               m_x[i] = 640;
               m_top[i] = gap_for(m_rnd, i);
            end else if (frame_tick && run_en) begin
               if (m_x[i] <= m_spd) begin
                  m_x[i] = m_x[i] + 640 - m_spd;
                  m_top[i] = gap_for(m_rnd, i);
               end else begin
                  if (m_x[i] + 40 > 160 && m_x[i] - m_spd + 40 <= 160) m_sc[i] = 1;
                  m_x[i] = m_x[i] - m_spd;
               end
            end
         end
         if (speed_up && !speed_down && m_spd < 6) m_spd++;
         else if (speed_down && !speed_up && m_spd > 1) m_spd--;
         m_rnd = next_rnd(m_rnd);
      end
   end

   // full comparison every clock, away from the edge
   always @(negedge clk) begin
      if (compare && !done) begin
         for (int i = 0; i < NC; i++) begin
            chk(int'(col_x[i]) == m_x[i], "R2 R3 R7 x", int'(col_x[i]), m_x[i]);
            chk(int'(gap_top[i]) == m_top[i], "R4 top", int'(gap_top[i]), m_top[i]);
            chk(int'(gap_bot[i]) == m_top[i] + 120, "R5 bottom", int'(gap_bot[i]), m_top[i] + 120);
            chk(int'(col_scored[i]) == m_sc[i], "R8 scored", int'(col_scored[i]), m_sc[i]);
         end
      end
   end

   task automatic cyc(bit t, bit r, bit up, bit dn, logic [NC-1:0] k);
      frame_tick = t; run_en = r; speed_up = up; speed_down = dn; col_kill = k;
      @(negedge clk);
      frame_tick = 1'b0; speed_up = 1'b0; speed_down = 1'b0; col_kill = '0;
   endtask

   function automatic int widest();
      int b = 0;
      for (int i = 1; i < NC; i++) if (col_x[i] > col_x[b]) b = i;
      return b;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      finish_run();
   end

   initial begin
      int k, x0, sc_total;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset values
      for (int i = 0; i < NC; i++) begin
         chk(int'(col_x[i]) == 160 + 160 * i, "R1 x", int'(col_x[i]), 160 + 160 * i);
         chk(int'(gap_top[i]) == 180, "R1 top", int'(gap_top[i]), 180);
         chk(int'(gap_bot[i]) == 300, "R1 bottom", int'(gap_bot[i]), 300);
         chk(col_scored[i] == 1'b0, "R1 scored", int'(col_scored[i]), 0);
      end
      compare = 1'b1;

      // R2 default speed 2, one tick
      k = widest(); x0 = int'(col_x[k]);
      cyc(1, 1, 0, 0, '0);
      chk(int'(col_x[k]) == x0 - 2, "R2 default step", int'(col_x[k]), x0 - 2);

      // R2 run low: ticks have no effect
      x0 = int'(col_x[k]);
      repeat (5) cyc(1, 0, 0, 0, '0);
      chk(int'(col_x[k]) == x0, "R2 run low hold", int'(col_x[k]), x0);

      // long run at default speed to force wraps and scores (R3 R8)
      sc_total = 0;
      for (int n = 0; n < 700; n++) begin
         cyc(n % 2 == 0, 1, 0, 0, '0);
         sc_total += $countones(col_scored);
      end
      chk(sc_total > 0, "R8 scores seen", sc_total, 1);

      // R6 upper clamp; strobe with tick uses old speed
      repeat (8) cyc(0, 1, 1, 0, '0);
      k = widest(); x0 = int'(col_x[k]);
      cyc(1, 1, 0, 1, '0);
      chk(int'(col_x[k]) == x0 - 6, "R6 clamp high", int'(col_x[k]), x0 - 6);
      k = widest(); x0 = int'(col_x[k]);
      cyc(1, 1, 0, 0, '0);
      chk(int'(col_x[k]) == x0 - 5, "R6 new speed next edge", int'(col_x[k]), x0 - 5);

      // R6 both strobes cancel
      cyc(0, 1, 1, 1, '0);
      k = widest(); x0 = int'(col_x[k]);
      cyc(1, 1, 0, 0, '0);
      chk(int'(col_x[k]) == x0 - 5, "R6 both strobes", int'(col_x[k]), x0 - 5);

      // R6 lower clamp
      repeat (9) cyc(0, 1, 0, 1, '0);
      k = widest(); x0 = int'(col_x[k]);
      cyc(1, 1, 0, 0, '0);
      chk(int'(col_x[k]) == x0 - 1, "R6 clamp low", int'(col_x[k]), x0 - 1);

      // R7 destroy with tick in same cycle, and with run low
      cyc(1, 1, 0, 0, 4'b0010);
      chk(int'(col_x[1]) == 640, "R7 kill beats tick", int'(col_x[1]), 640);
      chk(col_scored[1] == 1'b0, "R7 no score", int'(col_scored[1]), 0);
      cyc(0, 0, 0, 0, 4'b1001);
      chk(int'(col_x[0]) == 640, "R7 kill run low col0", int'(col_x[0]), 640);
      chk(int'(col_x[3]) == 640, "R7 kill run low col3", int'(col_x[3]), 640);

      // random mix with speed and destroy collisions
      for (int n = 0; n < 12000; n++) begin
         logic [NC-1:0] kk;
         for (int i = 0; i < NC; i++) kk[i] = ($urandom % 61) == 0;
         cyc(($urandom % 2) == 0, ($urandom % 8) != 0,
             ($urandom % 23) == 0, ($urandom % 19) == 0, kk);
      end

      // R5 band after all the churn
      for (int i = 0; i < NC; i++) begin
         chk(gap_top[i] >= 9'd40 && gap_bot[i] <= 9'd440, "R5 band",
             int'(gap_top[i]), 40);
      end
      finish_run();
   end

endmodule